// File: doc/BRIEF.md
# Dual-Clock Watchdog Timer

This block is a watchdog whose counter lives in a slow, always-on clock domain. Software configures and services it from a faster bus clock. Every bus write to one of the five programmable registers crosses into the slow domain through its own toggle handshake. While a crossing is still in flight, a per-register busy flag stays set. The register file holds prescaler control, counter, reload value, service trigger and run-control key.

While running, the counter steps upward, either on every slow cycle or once every 2^r slow cycles when the prescaler is enabled. Stepping past the all-ones value reloads the counter from the reload register and fires a fixed-length reset pulse. Firmware services the watchdog by writing a trigger value that differs from the one the register already holds, which reloads the counter without a pulse. Starting and stopping each need a pair of key words written back to back. Firmware is expected to stop the timer, change the counter, reload or prescaler setting, wait for the busy flags to clear, and then restart.

Top module: `wdt_sync_timer`

## Requirements
- R1: After reset the timer is stopped, reads of word addresses 0 to 5 all return zero, and the reset output is low.
- R2: Word address map: 0 control, 1 counter, 2 reload, 3 trigger, 4 key, 5 busy status. Status bit i is the busy flag of address i. An accepted write sets that flag in the bus cycle after the write. The flag clears once the value is in use in the slow domain, and after that a read of the address returns the written value.
- R3: A write to an address whose busy flag is set is dropped, and the earlier value stays in place.
- R4: While the timer is stopped, the counter keeps its value.
- R5: Writing 0x0000BBBB then 0x00004444 to the key address starts the timer. Writing 0x0000AAAA then 0x00005555 stops it. The run state changes only on the second write of a pair.
- R6: Any other key value, or a wrong second value (including the second word of the other pair), leaves the run state as it was and starts the pairing over.
- R7: Control bit 0 enables the prescaler, and control bits 3:1 hold the ratio r. With the prescaler off, a running counter advances by one every slow cycle. With it on, the counter advances by one every 2^r slow cycles.
- R8: Writing a trigger value that differs from the current trigger contents reloads the counter from the reload register and produces no reset pulse. Writing the same value again leaves the count untouched.
- R9: When a running counter steps from all ones, it takes the reload value on that same slow edge, and the reset output rises on that edge.
- R10: The reset pulse stays high for exactly 16 slow cycles, and the counter keeps advancing from the reload value during the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Bus-side clock for register writes and the busy flags |
| clk_slow | input | 1 | Slow counter clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, sampled on clk_bus |
| bus_addr | input | 3 | Word address for both writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdt_rst | output | 1 | Reset pulse, in the slow domain |

## Verification
The bench goes after the key pairing with a foreign word placed between the two start words, and with a cross-paired start then stop. A design that armed on any occurrence of the second word would start or stop when it should not. It overwrites a busy register at once: a design that did not guard the busy flag would keep the later value. A same-value trigger write is made well into a run, where a design that reloaded on every trigger write would show a counter that had dropped back. The wrap case checks that the counter equals the reload value exactly when the pulse rises, that the pulse lasts sixteen slow cycles, and that the count continues from the reload value. An off-by-one in the prescaler compare or in the pulse counter shows up as a wrong tick count in those measured windows.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int NREG   = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_COUNT = 3'd1,
        A_LOAD  = 3'd2,
        A_TRIG  = 3'd3,
        A_KEY   = 3'd4,
        A_STAT  = 3'd5
    } reg_addr_e;

    localparam logic [DATA_W-1:0] KEY_RUN_A  = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_RUN_B  = 32'h0000_4444;
    localparam logic [DATA_W-1:0] KEY_HALT_A = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_HALT_B = 32'h0000_5555;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_HALT = 2'd2
    } key_seq_e;

endpackage

// File: rtl/wdt_xfer.sv
// One register crossing: the bus side holds the data and flips a request
// toggle; the slow side sees the toggle change through two flops, raises a
// one-cycle commit and echoes the toggle back as the acknowledge.
module wdt_xfer #(
    parameter int W = 32
) (
    input  logic         clk_bus,
    input  logic         clk_slow,
    input  logic         rst_n,
    input  logic         wr_go,
    input  logic [W-1:0] wr_data,
    output logic         pending,
    output logic         commit,
    output logic [W-1:0] commit_data
);

    typedef struct packed {
        logic         req;
        logic         ack_m;
        logic         ack_s;
        logic [W-1:0] data;
    } bus_st_t;

    typedef struct packed {
        logic req_m;
        logic req_s;
        logic req_p;
        logic ack;
    } slow_st_t;

    bus_st_t  b_d, b_q;
    slow_st_t s_d, s_q;

    always_comb begin
        b_d       = b_q;
        b_d.ack_m = s_q.ack;
        b_d.ack_s = b_q.ack_m;
        if (wr_go) begin
            b_d.req  = ~b_q.req;
            b_d.data = wr_data;
        end
    end

    always_ff @(posedge clk_bus or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    always_comb begin
        s_d       = s_q;
        s_d.req_m = b_q.req;
        s_d.req_s = s_q.req_m;
        s_d.req_p = s_q.req_s;
        s_d.ack   = s_q.req_s;
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pending     = b_q.req ^ b_q.ack_s;
    assign commit      = s_q.req_s ^ s_q.req_p;
    assign commit_data = b_q.data;

endmodule

// File: rtl/wdt_core.sv
// Slow-domain state: committed registers, key pairing, prescaler, counter
// and reset pulse.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int RATIO_W   = 3,
    parameter int PULSE_LEN = 16
) (
    input  logic                         clk_slow,
    input  logic                         rst_n,
    input  logic [NREG-1:0]              commit,
    input  logic [NREG-1:0][DATA_W-1:0]  cdata,
    output logic [DATA_W-1:0]            ctrl_val,
    output logic [CNT_W-1:0]             count_val,
    output logic [CNT_W-1:0]             load_val,
    output logic [DATA_W-1:0]            trig_val,
    output logic [DATA_W-1:0]            key_val,
    output logic                         running,
    output logic                         rst_pulse
);

    localparam int PRE_W = (1 << RATIO_W) - 1;
    localparam int PW    = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  load;
        logic [DATA_W-1:0] trig;
        logic [DATA_W-1:0] key;
        key_seq_e          seq;
        logic              run;
        logic [PRE_W-1:0]  pre;
        logic [PW-1:0]     pls;
    } st_t;

    st_t              d, q;
    logic [PRE_W-1:0] mask;
    logic             tick;

    always_comb begin
        d = q;

        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(q.ctrl[RATIO_W:1]));
        end
        tick = !q.ctrl[0] || (q.pre == mask);

        if (commit[A_CTRL]) d.ctrl = cdata[A_CTRL];
        if (commit[A_LOAD]) d.load = cdata[A_LOAD][CNT_W-1:0];

        if (commit[A_KEY]) begin
            d.key = cdata[A_KEY];
            if (q.seq == SEQ_RUN && cdata[A_KEY] == KEY_RUN_B) begin
                d.run = 1'b1;
                d.seq = SEQ_IDLE;
            end else if (q.seq == SEQ_HALT && cdata[A_KEY] == KEY_HALT_B) begin
                d.run = 1'b0;
                d.seq = SEQ_IDLE;
            end else if (cdata[A_KEY] == KEY_RUN_A) begin
                d.seq = SEQ_RUN;
            end else if (cdata[A_KEY] == KEY_HALT_A) begin
                d.seq = SEQ_HALT;
            end else begin
                d.seq = SEQ_IDLE;
            end
        end

        if (q.pls != '0) d.pls = q.pls - PW'(1);

        if (commit[A_COUNT]) begin
            d.cnt = cdata[A_COUNT][CNT_W-1:0];
            d.pre = '0;
        end else if (commit[A_TRIG] && (cdata[A_TRIG] != q.trig)) begin
            d.cnt = d.load;
            d.pre = '0;
        end else if (q.run) begin
            if (tick) begin
                d.pre = '0;
                if (&q.cnt) begin
                    d.cnt = d.load;
                    d.pls = PW'(PULSE_LEN);
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end else begin
                d.pre = q.pre + PRE_W'(1);
            end
        end

        if (commit[A_TRIG]) d.trig = cdata[A_TRIG];
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl_val  = q.ctrl;
    assign count_val = q.cnt;
    assign load_val  = q.load;
    assign trig_val  = q.trig;
    assign key_val   = q.key;
    assign running   = q.run;
    assign rst_pulse = (q.pls != '0);

endmodule

// File: rtl/wdt_sync_timer.sv
module wdt_sync_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int RATIO_W   = 3,
    parameter int PULSE_LEN = 16
) (
    input  logic        clk_bus,
    input  logic        clk_slow,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_rst
);

    logic [NREG-1:0]             wr_acc;
    logic [NREG-1:0]             pending;
    logic [NREG-1:0]             s_commit;
    logic [NREG-1:0][DATA_W-1:0] cdata;
    logic [DATA_W-1:0]           ctrl_now, trig_now, key_now;
    logic [CNT_W-1:0]            cnt_now, load_now;
    logic                        run_now;

    for (genvar i = 0; i < NREG; i++) begin : g_xfer
        assign wr_acc[i] = bus_wr && (bus_addr == ADDR_W'(i)) && !pending[i];

        wdt_xfer #(.W(DATA_W)) u_xfer (
            .clk_bus     (clk_bus),
            .clk_slow    (clk_slow),
            .rst_n       (rst_n),
            .wr_go       (wr_acc[i]),
            .wr_data     (bus_wdata),
            .pending     (pending[i]),
            .commit      (s_commit[i]),
            .commit_data (cdata[i])
        );
    end

    wdt_core #(
        .CNT_W     (CNT_W),
        .RATIO_W   (RATIO_W),
        .PULSE_LEN (PULSE_LEN)
    ) u_core (
        .clk_slow  (clk_slow),
        .rst_n     (rst_n),
        .commit    (s_commit),
        .cdata     (cdata),
        .ctrl_val  (ctrl_now),
        .count_val (cnt_now),
        .load_val  (load_now),
        .trig_val  (trig_now),
        .key_val   (key_now),
        .running   (run_now),
        .rst_pulse (wdt_rst)
    );

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_now;
            A_COUNT: bus_rdata = DATA_W'(cnt_now);
            A_LOAD:  bus_rdata = DATA_W'(load_now);
            A_TRIG:  bus_rdata = trig_now;
            A_KEY:   bus_rdata = key_now;
            A_STAT:  bus_rdata = DATA_W'(pending);
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W     = 32,
    parameter int PULSE_LEN = 16,
    parameter int NREG      = 5
) (
    input logic             clk_bus,
    input logic             clk_slow,
    input logic             rst_n,
    input logic [NREG-1:0]  wr_acc,
    input logic [NREG-1:0]  pending,
    input logic             commit_cnt,
    input logic             commit_trig,
    input logic             commit_key,
    input logic             running,
    input logic [CNT_W-1:0] count_val,
    input logic [CNT_W-1:0] load_val,
    input logic             wdt_rst
);

    int unsigned hi_len;

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n)       hi_len <= 0;
        else if (wdt_rst) hi_len <= hi_len + 1;
        else              hi_len <= 0;
    end

    p_busy_set_r2: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (|wr_acc) |=> ((pending & $past(wr_acc)) == $past(wr_acc)));

    p_hold_stopped_r4: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (!running && !commit_cnt && !commit_trig) |=> $stable(count_val));

    p_start_by_key_r5: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $rose(running) |-> $past(commit_key));

    p_wrap_reload_r9: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $rose(wdt_rst) |-> (count_val == load_val));

    p_pulse_len_r10: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $fell(wdt_rst) |-> (hi_len >= PULSE_LEN));

endmodule

bind wdt_sync_timer wdt_checker #(
    .CNT_W     (CNT_W),
    .PULSE_LEN (PULSE_LEN),
    .NREG      (wdt_pkg::NREG)
) u_chk (
    .clk_bus     (clk_bus),
    .clk_slow    (clk_slow),
    .rst_n       (rst_n),
    .wr_acc      (wr_acc),
    .pending     (pending),
    .commit_cnt  (s_commit[1]),
    .commit_trig (s_commit[3]),
    .commit_key  (s_commit[4]),
    .running     (run_now),
    .count_val   (cnt_now),
    .load_val    (load_now),
    .wdt_rst     (wdt_rst)
);

// File: tb/sim_wdt_sync_timer.sv
module sim_wdt_sync_timer;

    localparam int BUS_PERIOD  = 10;
    localparam int SLOW_PERIOD = 70;

    logic        clk_bus = 1'b0;
    logic        clk_slow = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst;

    int tests = 0;
    int fails = 0;
    bit rst_seen = 1'b0;

    always #(BUS_PERIOD/2) clk_bus = ~clk_bus;
    initial begin
        #3;
        forever #(SLOW_PERIOD/2) clk_slow = ~clk_slow;
    end

    always @(posedge wdt_rst) rst_seen = 1'b1;

    wdt_sync_timer u0 (
        .clk_bus   (clk_bus),
        .clk_slow  (clk_slow),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wdt_rst   (wdt_rst)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk_bus);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk_bus);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle();
        logic [31:0] s;
        int n = 0;
        rd(3'd5, s);
        while (s[4:0] != 5'd0 && n < 2000) begin
            @(negedge clk_bus);
            rd(3'd5, s);
            n++;
        end
        if (n >= 2000) check(1'b0, "R2 busy never cleared", s, 32'h0);
    endtask

    task automatic wr_idle(input logic [2:0] a, input logic [31:0] v);
        wr(a, v);
        idle();
    endtask

    task automatic keys(input logic [31:0] k1, input logic [31:0] k2);
        wr_idle(3'd4, k1);
        wr_idle(3'd4, k2);
    endtask

    task automatic delta(input int k, output logic [31:0] dl);
        logic [31:0] c0, c1;
        @(negedge clk_slow);
        rd(3'd1, c0);
        repeat (k) @(negedge clk_slow);
        rd(3'd1, c1);
        dl = c1 - c0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check(v == 32'h0, "R1 reset read", v, 32'h0);
        end
        check(wdt_rst == 1'b0, "R1 reset output low", 32'(wdt_rst), 32'h0);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        wr(3'd2, 32'h1111_0000);
        rd(3'd5, v);
        check(v == 32'h4, "R2 busy flag of reload", v, 32'h4);
        wr(3'd2, 32'h2222_0000);   // R3: lands while busy
        idle();
        rd(3'd5, v);
        check(v == 32'h0, "R2 busy cleared", v, 32'h0);
        rd(3'd2, v);
        check(v == 32'h1111_0000, "R3 busy write dropped", v, 32'h1111_0000);
    endtask

    task automatic t_stopped();
        logic [31:0] v;
        wr_idle(3'd1, 32'd100);
        delta(20, v);
        check(v == 32'd0, "R4 stopped counter holds", v, 32'd0);
        rd(3'd1, v);
        check(v == 32'd100, "R4 counter value", v, 32'd100);
    endtask

    task automatic t_run_and_prescale();
        logic [31:0] v;
        keys(32'h0000_BBBB, 32'h0000_4444);
        delta(20, v);
        check(v == 32'd20, "R5 start / R7 one per cycle", v, 32'd20);
        keys(32'h0000_AAAA, 32'h0000_5555);
        delta(10, v);
        check(v == 32'd0, "R5 stop", v, 32'd0);
        wr_idle(3'd0, 32'h5);      // enable, ratio 2
        keys(32'h0000_BBBB, 32'h0000_4444);
        delta(16, v);
        check(v == 32'd4, "R7 prescale ratio 2", v, 32'd4);
        keys(32'h0000_AAAA, 32'h0000_5555);
        wr_idle(3'd0, 32'h0);
    endtask

    task automatic t_badkeys();
        logic [31:0] v;
        wr_idle(3'd4, 32'h0000_BBBB);
        wr_idle(3'd4, 32'h0000_1234);
        wr_idle(3'd4, 32'h0000_4444);
        delta(10, v);
        check(v == 32'd0, "R6 broken start pair", v, 32'd0);
        keys(32'h0000_AAAA, 32'h0000_4444);
        delta(10, v);
        check(v == 32'd0, "R6 cross pair stays stopped", v, 32'd0);
        keys(32'h0000_BBBB, 32'h0000_4444);
        keys(32'h0000_BBBB, 32'h0000_5555);
        delta(8, v);
        check(v == 32'd8, "R6 cross pair keeps running", v, 32'd8);
    endtask

    task automatic t_trigger();
        logic [31:0] c, cb, v;
        keys(32'h0000_AAAA, 32'h0000_5555);
        wr_idle(3'd2, 32'h500);
        keys(32'h0000_BBBB, 32'h0000_4444);
        repeat (30) @(negedge clk_slow);
        rst_seen = 1'b0;
        wr_idle(3'd3, 32'h1);
        @(negedge clk_slow);
        rd(3'd1, c);
        check(c >= 32'h500 && c < 32'h508, "R8 changed trigger reloads", c, 32'h500);
        check(rst_seen == 1'b0, "R8 no pulse on service", 32'(rst_seen), 32'h0);
        rd(3'd3, v);
        check(v == 32'h1, "R2 trigger readback", v, 32'h1);
        repeat (40) @(negedge clk_slow);
        rd(3'd1, cb);
        wr_idle(3'd3, 32'h1);
        @(negedge clk_slow);
        rd(3'd1, c);
        check(c > cb, "R8 same trigger no reload", c, cb);
    endtask

    task automatic t_wrap();
        logic [31:0] c;
        int n = 0;
        int len;
        keys(32'h0000_AAAA, 32'h0000_5555);
        wr_idle(3'd1, 32'hFFFF_FFF0);
        wr_idle(3'd2, 32'h0000_1234);
        keys(32'h0000_BBBB, 32'h0000_4444);
        while (!wdt_rst && n < 300) begin
            @(negedge clk_slow);
            n++;
        end
        check(wdt_rst == 1'b1, "R9 pulse after wrap", 32'(wdt_rst), 32'h1);
        rd(3'd1, c);
        check(c == 32'h1234, "R9 reload on wrap", c, 32'h1234);
        len = 1;
        while (wdt_rst && len < 100) begin
            @(negedge clk_slow);
            if (wdt_rst) len++;
        end
        check(len == 16, "R10 pulse length", 32'(len), 32'd16);
        rd(3'd1, c);
        check(c == 32'h1244, "R10 counting through pulse", c, 32'h1244);
    endtask

    initial begin
        #(BUS_PERIOD * 150000);
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk_bus);
        rst_n = 1'b1;
        repeat (4) @(negedge clk_bus);
        t_reset();
        t_busy();
        t_stopped();
        t_run_and_prescale();
        t_badkeys();
        t_trigger();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule